// File: doc/BRIEF.md
# Preemptive Sound Effect Player

This block plays three short sound clips stored as raw 16-bit signed samples in an on-chip read-only image. It streams the selected clip to an external audio codec over a three-wire serial audio link: a bit clock, a word select and a data line. The three clips are the player's shot, an explosion and an enemy attack. Each clip is a run of consecutive ROM words set by a start-address parameter and a length parameter. The ROM holds no header or trailer, so every word in the run is a sample.

All three clips share one output, and the most recent request wins. A pulse on any trigger input cuts off the clip in progress and starts the requested clip from its first sample. When several triggers arrive in the same clock, a fixed priority picks one. The serial frame also sets the sample rate. A divider makes one bit slot every `BIT_DIV` system clocks, and thirty-two slots form one frame. One new sample is loaded at each frame boundary and sent on both channels. A parameter selects either a one-slot-delayed (I2S) data alignment or left-justified alignment. When a clip has sent its last sample the block goes silent and sends zero words.

Top module: `sfx_player`

## Requirements
- R1: Each bit slot lasts `BIT_DIV` clocks. `bclk` is low in the first `BIT_DIV/2` clocks of a slot and high in the rest. A frame is 32 slots, and exactly `32*BIT_DIV` clocks pass between successive sample loads.
- R2: `lrclk` is 0 in slots 0–15 of a frame (left) and 1 in slots 16–31 (right). Both channels carry the same 16-bit sample, most significant bit first. `sample_o` shows the word being sent and changes only at a frame boundary.
- R3: With `I2S_MODE=1`, the data line lags by one slot. Slot 0 carries bit 0 of the previous frame's word, slot k (1–15) carries bit 16−k, slot 16 carries bit 0 and slot 16+k carries bit 16−k. With `I2S_MODE=0`, slot s carries bit 15−(s mod 16).
- R4: A trigger sets `busy` on the next clock. The clip's first sample is loaded at the next frame boundary, or at that same edge if the trigger is sampled on the boundary edge itself. Each following frame loads the next consecutive word. The ROM word at address a is {a[7:0] xor 8'hA5, a[7:0] + 8'h11}.
- R5: A trigger that arrives while a clip is playing abandons that clip and restarts from the first sample of the newly requested clip.
- R6: Triggers that arrive in the same clock are resolved with shot first, then explosion, then attack.
- R7: After a clip's last sample has been loaded, `busy` is low. Every later frame sends the word zero until the next trigger.
- R8: After reset, `busy`, `sample_o`, `bclk`, `lrclk` and `sdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_shot | input | 1 | Request the player-shot clip |
| trig_boom | input | 1 | Request the explosion clip |
| trig_attack | input | 1 | Request the enemy-attack clip |
| busy | output | 1 | High while a clip still has samples to load |
| sample_o | output | 16 | Sample word currently being sent |
| bclk | output | 1 | Serial bit clock to the codec |
| lrclk | output | 1 | Word select: 0 left, 1 right |
| sdata | output | 1 | Serial sample data |

## Verification
The bench aims at several edge cases:
- A trigger sampled on exactly the frame-boundary edge. A design that loaded the stale clip there would send one frame of the old sound.
- A preemption partway through an explosion. A design that resumed the old index or ignored the new request would send the wrong word sequence.
- Simultaneous triggers. These expose a reversed priority.
- The end of each clip. An off-by-one here either sends one word past the clip or cuts its last word.

The data line is compared in both alignments every clock. This includes slot 0 in the delayed mode, which must repeat the previous frame's least significant bit rather than the new word's.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

    localparam int SAMPLE_W    = 16;
    localparam int CHANNELS    = 2;
    localparam int FRAME_SLOTS = SAMPLE_W * CHANNELS;
    localparam int SLOT_W      = $clog2(FRAME_SLOTS);
    localparam int POS_W       = $clog2(SAMPLE_W);
    localparam int NUM_CLIPS   = 3;

    // Trigger bit order doubles as priority order: lower index wins.
    typedef enum logic [1:0] {
        CLIP_SHOT   = 2'd0,
        CLIP_BOOM   = 2'd1,
        CLIP_ATTACK = 2'd2
    } clip_e;

    typedef logic [SAMPLE_W-1:0] sample_t;

endpackage

// File: rtl/sfx_tick_gen.sv
module sfx_tick_gen
    import sfx_pkg::*;
#(
    parameter int BIT_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              bit_tick,
    output logic              frame_tick,
    output logic              bclk,
    output logic [SLOT_W-1:0] slot
);

    localparam int DIV_W      = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1;
    localparam int FRAME_CLKS = BIT_DIV * FRAME_SLOTS;
    localparam int GAP_W      = $clog2(FRAME_CLKS + 1);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [SLOT_W-1:0] slot;
    } tick_st_t;

    tick_st_t st_q, st_d;

    always_comb begin
        bit_tick   = (st_q.div == DIV_W'(BIT_DIV - 1));
        frame_tick = bit_tick && (st_q.slot == SLOT_W'(FRAME_SLOTS - 1));
        bclk       = (st_q.div >= DIV_W'(BIT_DIV / 2));
        slot       = st_q.slot;

        st_d = st_q;
        if (bit_tick) begin
            st_d.div  = '0;
            st_d.slot = frame_tick ? '0 : st_q.slot + 1'b1;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Checker counter: clocks since the last frame boundary.
    logic [GAP_W-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          gap_q <= '0;
        else if (frame_tick) gap_q <= '0;
        else                 gap_q <= gap_q + 1'b1;
    end

    p_frame_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |-> (gap_q == GAP_W'(FRAME_CLKS - 1)));

    p_bclk_low_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bclk);

endmodule

// File: rtl/sfx_clip_rom.sv
module sfx_clip_rom
    import sfx_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic [ADDR_W-1:0] addr,
    output sample_t           data
);

    sample_t image [DEPTH];

    // Placeholder image: every word is nonzero, so silence is distinguishable.
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        assign image[g] = sample_t'({8'(g) ^ 8'hA5, 8'(g + 8'h11)});
    end

    assign data = image[addr];

endmodule

// File: rtl/sfx_sequencer.sv
module sfx_sequencer
    import sfx_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int SHOT_BASE   = 0,
    parameter int SHOT_LEN    = 5,
    parameter int BOOM_BASE   = 8,
    parameter int BOOM_LEN    = 12,
    parameter int ATTACK_BASE = 24,
    parameter int ATTACK_LEN  = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CLIPS-1:0] trig,
    input  logic                 frame_tick,
    input  sample_t              rom_data,
    output logic [ADDR_W-1:0]    rom_addr,
    output sample_t              sample,
    output logic                 busy
);

    localparam int MAX_AB  = (SHOT_LEN > BOOM_LEN) ? SHOT_LEN : BOOM_LEN;
    localparam int MAX_LEN = (MAX_AB > ATTACK_LEN) ? MAX_AB : ATTACK_LEN;
    localparam int IDX_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

    typedef struct packed {
        logic             active;
        clip_e            clip;
        logic [IDX_W-1:0] idx;
        sample_t          sample;
    } seq_st_t;

    seq_st_t st_q, st_d;
    seq_st_t eff;

    function automatic logic [ADDR_W-1:0] base_of(input clip_e c);
        case (c)
            CLIP_SHOT: return ADDR_W'(SHOT_BASE);
            CLIP_BOOM: return ADDR_W'(BOOM_BASE);
            default:   return ADDR_W'(ATTACK_BASE);
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] last_of(input clip_e c);
        case (c)
            CLIP_SHOT: return IDX_W'(SHOT_LEN - 1);
            CLIP_BOOM: return IDX_W'(BOOM_LEN - 1);
            default:   return IDX_W'(ATTACK_LEN - 1);
        endcase
    endfunction

    always_comb begin
        // Recency: any request this cycle replaces the clip in progress.
        eff = st_q;
        for (int i = NUM_CLIPS - 1; i >= 0; i--) begin
            if (trig[i]) begin
                eff.active = 1'b1;
                eff.clip   = clip_e'(i);
                eff.idx    = '0;
            end
        end

        rom_addr = base_of(eff.clip) + ADDR_W'(eff.idx);

        st_d = eff;
        if (frame_tick) begin
            if (eff.active) begin
                st_d.sample = rom_data;
                if (eff.idx == last_of(eff.clip)) begin
                    st_d.active = 1'b0;
                    st_d.idx    = '0;
                end else begin
                    st_d.idx = eff.idx + 1'b1;
                end
            end else begin
                st_d.sample = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{active: 1'b0, clip: CLIP_SHOT, idx: '0, sample: '0};
        else        st_q <= st_d;
    end

    assign sample = st_q.sample;
    assign busy   = st_q.active;

    p_trig_arms_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|trig) |=> busy);

    p_arm_needs_trig_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(|trig)) |=> !busy);

    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|trig) && !frame_tick) |=> (st_q.idx == '0));

    p_shot_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trig[0] |=> (st_q.clip == CLIP_SHOT));

    p_boom_over_attack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig[1] && !trig[0]) |=> (st_q.clip == CLIP_BOOM));

    p_idle_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(|trig) && frame_tick) |=> (sample == '0));

endmodule

// File: rtl/sfx_serializer.sv
module sfx_serializer
    import sfx_pkg::*;
#(
    parameter int I2S_MODE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              frame_tick,
    input  logic [SLOT_W-1:0] slot,
    input  sample_t           sample,
    output logic              ws,
    output logic              sdata
);

    typedef struct packed {
        logic prev_lsb;
    } ser_st_t;

    ser_st_t st_q, st_d;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] sel;

    always_comb begin
        pos = slot[POS_W-1:0];
        ws  = (slot >= SLOT_W'(SAMPLE_W));
        st_d = st_q;
        if (frame_tick) st_d.prev_lsb = sample[0];
    end

    if (I2S_MODE != 0) begin : g_delayed
        always_comb begin
            sel   = POS_W'(0) - pos;
            sdata = (slot == '0) ? st_q.prev_lsb : sample[sel];
        end
    end else begin : g_left_just
        always_comb begin
            sel   = ~pos;
            sdata = sample[sel];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_ws_on_slot_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(ws));

    p_word_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(sample));

    p_left_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> !ws);

endmodule

// File: rtl/sfx_player.sv
module sfx_player
    import sfx_pkg::*;
#(
    parameter int BIT_DIV     = 4,
    parameter int I2S_MODE    = 1,
    parameter int ROM_DEPTH   = 64,
    parameter int SHOT_BASE   = 0,
    parameter int SHOT_LEN    = 5,
    parameter int BOOM_BASE   = 8,
    parameter int BOOM_LEN    = 12,
    parameter int ATTACK_BASE = 24,
    parameter int ATTACK_LEN  = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trig_shot,
    input  logic        trig_boom,
    input  logic        trig_attack,
    output logic        busy,
    output logic [15:0] sample_o,
    output logic        bclk,
    output logic        lrclk,
    output logic        sdata
);

    localparam int ADDR_W = $clog2(ROM_DEPTH);

    logic              bit_tick;
    logic              frame_tick;
    logic [SLOT_W-1:0] slot;
    logic [ADDR_W-1:0] rom_addr;
    sample_t           rom_data;
    sample_t           sample;
    logic [NUM_CLIPS-1:0] trig;

    assign trig = {trig_attack, trig_boom, trig_shot};

    sfx_tick_gen #(.BIT_DIV(BIT_DIV)) i_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .frame_tick(frame_tick),
        .bclk      (bclk),
        .slot      (slot)
    );

    sfx_clip_rom #(.DEPTH(ROM_DEPTH), .ADDR_W(ADDR_W)) i_rom (
        .addr(rom_addr),
        .data(rom_data)
    );

    sfx_sequencer #(
        .ADDR_W     (ADDR_W),
        .SHOT_BASE  (SHOT_BASE),
        .SHOT_LEN   (SHOT_LEN),
        .BOOM_BASE  (BOOM_BASE),
        .BOOM_LEN   (BOOM_LEN),
        .ATTACK_BASE(ATTACK_BASE),
        .ATTACK_LEN (ATTACK_LEN)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .frame_tick(frame_tick),
        .rom_data  (rom_data),
        .rom_addr  (rom_addr),
        .sample    (sample),
        .busy      (busy)
    );

    sfx_serializer #(.I2S_MODE(I2S_MODE)) i_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .frame_tick(frame_tick),
        .slot      (slot),
        .sample    (sample),
        .ws        (lrclk),
        .sdata     (sdata)
    );

    assign sample_o = sample;

endmodule

// File: tb/test_sfx_player.sv
`timescale 1ns/1ps
module test_sfx_player;

    localparam int DIV   = 4;
    localparam int FRAME = 32 * DIV;
    localparam int SB = 0,  SL = 5;
    localparam int BB = 8,  BL = 12;
    localparam int AB = 24, AL = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic t_shot = 1'b0, t_boom = 1'b0, t_attack = 1'b0;

    logic        busy, bclk, lrclk, sdata, sdata_lj;
    logic        busy_lj, bclk_lj, lrclk_lj;
    logic [15:0] sample_o, sample_lj;

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sfx_player #(.BIT_DIV(DIV), .I2S_MODE(1),
        .SHOT_BASE(SB), .SHOT_LEN(SL), .BOOM_BASE(BB), .BOOM_LEN(BL),
        .ATTACK_BASE(AB), .ATTACK_LEN(AL)) i_sfx_player (
        .clk(clk), .rst_n(rst_n), .trig_shot(t_shot), .trig_boom(t_boom),
        .trig_attack(t_attack), .busy(busy), .sample_o(sample_o),
        .bclk(bclk), .lrclk(lrclk), .sdata(sdata));

    sfx_player #(.BIT_DIV(DIV), .I2S_MODE(0),
        .SHOT_BASE(SB), .SHOT_LEN(SL), .BOOM_BASE(BB), .BOOM_LEN(BL),
        .ATTACK_BASE(AB), .ATTACK_LEN(AL)) i_sfx_player_lj (
        .clk(clk), .rst_n(rst_n), .trig_shot(t_shot), .trig_boom(t_boom),
        .trig_attack(t_attack), .busy(busy_lj), .sample_o(sample_lj),
        .bclk(bclk_lj), .lrclk(lrclk_lj), .sdata(sdata_lj));

    function automatic logic [15:0] rom_val(input int a);
        logic [7:0] b;
        b = a[7:0];
        return {b ^ 8'hA5, b + 8'h11};
    endfunction

    // Behavioural reference: clocks counted as integers.
    int m_div = 0, m_slot = 0, m_base = 0, m_len = 0, m_n = 0;
    bit m_active = 0;
    logic [15:0] m_sample = '0, m_prev = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 0; m_slot = 0; m_active = 0; m_n = 0;
            m_sample = '0; m_prev = '0; m_base = 0; m_len = 0;
        end else begin
            if (t_shot)        begin m_active = 1; m_base = SB; m_len = SL; m_n = 0; end
            else if (t_boom)   begin m_active = 1; m_base = BB; m_len = BL; m_n = 0; end
            else if (t_attack) begin m_active = 1; m_base = AB; m_len = AL; m_n = 0; end
            if (m_div == DIV - 1 && m_slot == 31) begin
                m_prev = m_sample;
                if (m_active) begin
                    m_sample = rom_val(m_base + m_n);
                    m_n++;
                    if (m_n == m_len) begin m_active = 0; m_n = 0; end
                end else m_sample = '0;
            end
            if (m_div == DIV - 1) begin
                m_div = 0;
                m_slot = (m_slot + 1) % 32;
            end else m_div++;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic exp_i2s();
        int p = m_slot % 16;
        if (p == 0) return (m_slot == 0) ? m_prev[0] : m_sample[0];
        return m_sample[16 - p];
    endfunction

    always @(negedge clk) begin
        if (running) begin
            check("R1", "bclk", int'(bclk), int'(m_div >= DIV / 2));
            check("R2", "lrclk", int'(lrclk), int'(m_slot >= 16));
            check("R4", "sample_o", int'(sample_o), int'(m_sample));
            check("R7", "busy", int'(busy), int'(m_active));
            check("R3", "sdata i2s", int'(sdata), int'(exp_i2s()));
            check("R3", "sdata lj", int'(sdata_lj), int'(m_sample[15 - (m_slot % 16)]));
            check("R2", "lj word", int'(sample_lj), int'(m_sample));
        end
    end

    task automatic align();
        @(negedge clk);
        while (!(m_div == 0 && m_slot == 0)) @(negedge clk);
    endtask

    task automatic pulse(input bit s, input bit b, input bit a);
        t_shot = s; t_boom = b; t_attack = a;
        @(negedge clk);
        t_shot = 0; t_boom = 0; t_attack = 0;
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_clks(4);
        // R8: reset values
        check("R8", "busy", int'(busy), 0);
        check("R8", "sample_o", int'(sample_o), 0);
        check("R8", "bclk", int'(bclk), 0);
        check("R8", "lrclk", int'(lrclk), 0);
        check("R8", "sdata", int'(sdata), 0);
        rst_n = 1'b1;
        running = 1'b1;
        wait_clks(2 * FRAME + 7);

        // R4: attack clip, first word at next frame boundary
        align();
        pulse(0, 0, 1);
        check("R4", "busy after trigger", int'(busy), 1);
        wait_clks(FRAME - 1);
        check("R4", "first attack word", int'(sample_o), int'(rom_val(AB)));
        wait_clks(FRAME);
        check("R4", "second attack word", int'(sample_o), int'(rom_val(AB + 1)));
        // R7: end of clip and silence
        wait_clks((AL - 2) * FRAME);
        check("R7", "last attack word", int'(sample_o), int'(rom_val(AB + AL - 1)));
        check("R7", "busy low at end", int'(busy), 0);
        wait_clks(FRAME);
        check("R7", "silence", int'(sample_o), 0);

        // R5: shot preempts explosion mid-clip
        align();
        pulse(0, 1, 0);
        wait_clks(3 * FRAME - 1);
        check("R5", "boom third word", int'(sample_o), int'(rom_val(BB + 2)));
        pulse(1, 0, 0);
        wait_clks(FRAME - 1);
        check("R5", "shot replaces boom", int'(sample_o), int'(rom_val(SB)));
        wait_clks((SL - 1) * FRAME);
        check("R5", "shot last word", int'(sample_o), int'(rom_val(SB + SL - 1)));
        check("R7", "busy low after shot", int'(busy), 0);
        wait_clks(2 * FRAME);

        // R6: simultaneous triggers
        align();
        pulse(1, 1, 1);
        wait_clks(FRAME - 1);
        check("R6", "shot wins all three", int'(sample_o), int'(rom_val(SB)));
        align();
        pulse(0, 1, 1);
        wait_clks(FRAME - 1);
        check("R6", "boom over attack", int'(sample_o), int'(rom_val(BB)));

        // R4: trigger sampled on the boundary edge itself
        @(negedge clk);
        while (!(m_div == DIV - 1 && m_slot == 31)) @(negedge clk);
        pulse(0, 0, 1);
        check("R4", "coincident load", int'(sample_o), int'(rom_val(AB)));

        // R5: trigger held several cycles keeps restarting
        wait_clks(5 * FRAME + 11);
        t_boom = 1; wait_clks(3 * FRAME); t_boom = 0;
        wait_clks((BL + 3) * FRAME);
        check("R7", "silence after held boom", int'(sample_o), 0);

        running = 1'b0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule